// File: doc/BRIEF.md
# NAND Command and Address Sequencer

This block is the host-side engine for an 8-bit NAND-style flash bus. A single start pulse hands it an operation code and a 27-bit byte address. It then drives the command and address strobes and the I/O byte through the bus cycles that open a page access, and pulses `done` when the last cycle is complete. Data bursts, ready/busy polling and ECC belong to other blocks.

The device page has 512 main bytes and 16 spare bytes. A block holds 32 pages, and the array holds 8192 blocks. Address bits A0..A7 give the column. Bits A9..A26 give the page: A9..A13 pick the page within its block and A14..A26 pick the block. Bit A8 never appears on the bus. Instead, it picks the read-pointer command: 00h for columns 0..255 and 01h for columns 256..511. The engine makes that choice from the address it is given.

Every bus cycle holds write-enable low for `WE_LOW` clocks and then high for `WE_HIGH` clocks. The I/O byte and the latch strobes stay steady across the rising edge.

Top module: `nand_cmd_addr_seq`

## Requirements
- R1: After reset, and whenever the engine is idle, the outputs are ce_n=1, we_n=1, re_n=1, cle=0, ale=0, io_oe=0, wp_n=0 and done=0.
- R2: A read request (op=0) sends one command cycle followed by four address cycles. The command byte is 00h when address bit 8 is 0 and 01h when it is 1.
- R3: The address cycles carry, in order: A7..A0, then A16..A9, then A24..A17, then a byte of {6'b0, A26, A25}. I/O bits 7..2 of the fourth cycle are zero.
- R4: A command cycle has cle=1 and ale=0. An address cycle has cle=0 and ale=1. ce_n=0 and re_n=1 hold for the whole sequence. cle and ale are never both high.
- R5: A program request (op=1) sends the read-pointer command (00h or 01h, chosen as in R2), then command 80h, then the four address cycles of R3.
- R6: An erase request (op=2) sends command 60h followed by three address cycles: A16..A9, A24..A17, and {6'b0, A26, A25}.
- R7: In each bus cycle, we_n is low for exactly WE_LOW clocks. Between two cycles of one sequence, we_n is high for exactly WE_HIGH clocks. io_out, cle and ale do not change on the clock at which we_n rises.
- R8: wp_n is 1 throughout program and erase sequences. It is 0 during read sequences and while idle.
- R9: done is high for exactly one clock. That clock follows the WE_HIGH high clocks of the last bus cycle, and in it the bus has already returned to idle.
- R10: A start pulse while a sequence is running is ignored. A start pulse with op=3 is ignored. Neither one changes the bus.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-clock request pulse |
| op | input | 2 | 0 read, 1 program, 2 erase, 3 reserved |
| addr | input | 27 | Byte address A26..A0 |
| cle | output | 1 | Command latch enable |
| ale | output | 1 | Address latch enable |
| ce_n | output | 1 | Chip enable, active low |
| we_n | output | 1 | Write enable strobe, active low |
| re_n | output | 1 | Read enable, held high |
| wp_n | output | 1 | Write protect, active low |
| io_out | output | 8 | Bus byte |
| io_oe | output | 8 | Bus output enable (all bits high while driving) |
| done | output | 1 | One-clock completion pulse |

## Verification
Each request is tried with address bit 8 clear and set, which shows whether the 00h/01h pointer choice follows that bit. The bench uses all-zero, all-one and alternating addresses. A dropped, swapped or shifted field shows up as a wrong byte, and the all-one address makes a missing zero pad in the fourth cycle visible. Read, program and erase are all sent, which separates the command lists and the three-cycle erase address. A start pulse during a program sequence and a reserved op code while idle show whether stray requests reach the bus.

// File: rtl/nand_cmd_addr_seq.sv
module nand_cmd_addr_seq #(
  parameter int TIMER_W = 4,
  parameter int WE_LOW = 2,
  parameter int WE_HIGH = 2,
  parameter logic [7:0] CMD_PTR_LO = 8'h00,
  parameter logic [7:0] CMD_PTR_HI = 8'h01,
  parameter logic [7:0] CMD_PROG = 8'h80,
  parameter logic [7:0] CMD_ERASE = 8'h60
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [1:0]  op,
  input  logic [26:0] addr,
  output logic        cle,
  output logic        ale,
  output logic        ce_n,
  output logic        we_n,
  output logic        re_n,
  output logic        wp_n,
  output logic [7:0]  io_out,
  output logic [7:0]  io_oe,
  output logic        done
);
  localparam logic [1:0] OP_READ = 2'd0;
  localparam logic [1:0] OP_PROG = 2'd1;
  localparam logic [1:0] OP_ERASE = 2'd2;
  localparam logic [TIMER_W-1:0] LO_LOAD = TIMER_W'(WE_LOW - 1);
  localparam logic [TIMER_W-1:0] HI_LOAD = TIMER_W'(WE_HIGH - 1);

  typedef enum logic [1:0] {S_IDLE, S_LO, S_HI} st_t;

  st_t st;
  logic [TIMER_W-1:0] tmr;
  logic [2:0] step;
  logic [1:0] op_q;
  logic [26:0] a_q;
  logic is_cmd;
  logic [7:0] byte_now;
  logic [2:0] last_step;
  logic [7:0] ab [4];

  wire active = (st != S_IDLE);
  wire [7:0] ptr_cmd = a_q[8] ? CMD_PTR_HI : CMD_PTR_LO;

  assign ab[0] = a_q[7:0];
  assign ab[1] = a_q[16:9];
  assign ab[2] = a_q[24:17];
  assign ab[3] = {6'b0, a_q[26:25]};

  always_comb begin
    is_cmd = 1'b0;
    byte_now = 8'h00;
    last_step = 3'd4;
    case (op_q)
      OP_PROG: begin
        last_step = 3'd5;
        case (step)
          3'd0: begin is_cmd = 1'b1; byte_now = ptr_cmd; end
          3'd1: begin is_cmd = 1'b1; byte_now = CMD_PROG; end
          3'd2: byte_now = ab[0];
          3'd3: byte_now = ab[1];
          3'd4: byte_now = ab[2];
          default: byte_now = ab[3];
        endcase
      end
      OP_ERASE: begin
        last_step = 3'd3;
        case (step)
          3'd0: begin is_cmd = 1'b1; byte_now = CMD_ERASE; end
          3'd1: byte_now = ab[1];
          3'd2: byte_now = ab[2];
          default: byte_now = ab[3];
        endcase
      end
      default: begin
        case (step)
          3'd0: begin is_cmd = 1'b1; byte_now = ptr_cmd; end
          3'd1: byte_now = ab[0];
          3'd2: byte_now = ab[1];
          3'd3: byte_now = ab[2];
          default: byte_now = ab[3];
        endcase
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      tmr <= '0;
      step <= '0;
      op_q <= OP_READ;
      a_q <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start && op != 2'd3) begin
          st <= S_LO;
          tmr <= LO_LOAD;
          step <= '0;
          op_q <= op;
          a_q <= addr;
        end
        S_LO: if (tmr == '0) begin
          st <= S_HI;
          tmr <= HI_LOAD;
        end else tmr <= tmr - 1'b1;
        S_HI: if (tmr != '0) tmr <= tmr - 1'b1;
        else if (step == last_step) begin
          st <= S_IDLE;
          done <= 1'b1;
        end else begin
          st <= S_LO;
          tmr <= LO_LOAD;
          step <= step + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign ce_n = !active;
  assign we_n = (st != S_LO);
  assign re_n = 1'b1;
  assign cle = active && is_cmd;
  assign ale = active && !is_cmd;
  assign io_out = active ? byte_now : 8'h00;
  assign io_oe = {8{active}};
  assign wp_n = active && (op_q == OP_PROG || op_q == OP_ERASE);
endmodule

// File: rtl/nand_seq_chk.sv
module nand_seq_chk #(
  parameter int WE_LOW = 2
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cle,
  input logic       ale,
  input logic       ce_n,
  input logic       we_n,
  input logic       re_n,
  input logic       wp_n,
  input logic [7:0] io_out,
  input logic [7:0] io_oe,
  input logic       done
);
  logic [15:0] lo_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lo_run <= '0;
    else if (!we_n) lo_run <= lo_run + 1'b1;
    else lo_run <= '0;
  end

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |-> (we_n && io_oe == 8'h00 && !cle && !ale && !wp_n));
  p_latch_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(cle && ale));
  p_re_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !ce_n |-> re_n);
  p_hold_on_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_n) |-> ($stable(io_out) && $stable(cle) && $stable(ale)));
  p_low_width_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_n) |-> (lo_run == 16'(WE_LOW)));
  p_wp_only_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wp_n |-> !ce_n);
  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (ce_n && $past(we_n) && !$past(ce_n)));
endmodule

bind nand_cmd_addr_seq nand_seq_chk #(.WE_LOW(WE_LOW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cle(cle), .ale(ale), .ce_n(ce_n), .we_n(we_n),
  .re_n(re_n), .wp_n(wp_n), .io_out(io_out), .io_oe(io_oe), .done(done)
);

// File: tb/sim_nand_cmd_addr_seq.sv
module sim_nand_cmd_addr_seq;
  localparam int WL = 2;
  localparam int WH = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [1:0] op = 2'd0;
  logic [26:0] addr = '0;
  logic cle, ale, ce_n, we_n, re_n, wp_n, done;
  logic [7:0] io_out, io_oe;

  int checks = 0;
  int errors = 0;
  int dones = 0;
  bit finished = 0;
  logic [9:0] exp_q[$];
  bit exp_wp = 0;

  always #10 clk = ~clk;

  nand_cmd_addr_seq #(.WE_LOW(WL), .WE_HIGH(WH)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .addr(addr),
    .cle(cle), .ale(ale), .ce_n(ce_n), .we_n(we_n), .re_n(re_n), .wp_n(wp_n),
    .io_out(io_out), .io_oe(io_oe), .done(done)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic push_addr4(input logic [26:0] a);
    exp_q.push_back({2'b01, a[7:0]});
    exp_q.push_back({2'b01, a[16:9]});
    exp_q.push_back({2'b01, a[24:17]});
    exp_q.push_back({2'b01, 6'b0, a[26:25]});
  endtask

  task automatic do_req(input logic [1:0] o, input logic [26:0] a, input bit stray);
    logic [7:0] ptr;
    ptr = a[8] ? 8'h01 : 8'h00;
    exp_wp = (o != 2'd0);
    if (o == 2'd0) begin
      exp_q.push_back({2'b10, ptr});
      push_addr4(a);
    end else if (o == 2'd1) begin
      exp_q.push_back({2'b10, ptr});
      exp_q.push_back({2'b10, 8'h80});
      push_addr4(a);
    end else begin
      exp_q.push_back({2'b10, 8'h60});
      exp_q.push_back({2'b01, a[16:9]});
      exp_q.push_back({2'b01, a[24:17]});
      exp_q.push_back({2'b01, 6'b0, a[26:25]});
    end
    @(negedge clk);
    start = 1'b1; op = o; addr = a;
    @(negedge clk);
    start = 1'b0; op = 2'd0; addr = '0;
    if (stray) begin
      repeat (5) @(negedge clk);
      start = 1'b1; op = 2'd2; addr = 27'h1234567;
      @(negedge clk);
      start = 1'b0; op = 2'd0; addr = '0;
    end
    while (!done) @(negedge clk);
    @(negedge clk);
    check(exp_q.size() == 0, "R9", "items left at done", exp_q.size(), 0);
  endtask

  int lo_run = 0;
  int hi_run = 0;
  logic we_prev = 1'b1;
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (!we_prev && we_n) begin
        logic [9:0] got;
        got = {cle, ale, io_out};
        check(lo_run == WL, "R7", "we_n low width", lo_run, WL);
        check(!ce_n && re_n && io_oe == 8'hFF, "R4", "ce_n/re_n/io_oe",
              {ce_n, re_n, io_oe}, {2'b01, 8'hFF});
        check(wp_n == exp_wp, "R8", "wp_n", wp_n, exp_wp);
        if (exp_q.size() == 0) check(1'b0, "R10", "unexpected bus cycle", got, 0);
        else begin
          logic [9:0] e;
          e = exp_q.pop_front();
          check(got == e, e[9] ? "R2/R5/R6" : "R3", "cycle {cle,ale,io}", got, e);
        end
      end
      if (we_prev && !we_n && hi_run != 0)
        check(hi_run == WH, "R7", "we_n high gap", hi_run, WH);
      if (done) begin
        dones++;
        check(hi_run == WH && ce_n, "R9", "done timing", hi_run, WH);
      end
      if (!we_n) begin lo_run++; hi_run = 0; end
      else begin
        lo_run = 0;
        if (!ce_n) hi_run++;
      end
      we_prev = we_n;
    end
  end

  task automatic finish_run();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "WATCHDOG", "timeout", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(ce_n && we_n && re_n && !cle && !ale && io_oe == 0 && !wp_n && !done,
          "R1", "reset outputs",
          {ce_n, we_n, re_n, cle, ale, wp_n, done, io_oe}, {3'b111, 4'b0, 8'h00});
    do_req(2'd0, 27'h0000000, 0);        // R2 low half
    do_req(2'd0, 27'h5A5A5A5, 0);        // R2 bit8 set -> 01h, R3 fields
    do_req(2'd0, 27'h7FFFFFF, 0);        // R3 top pad
    do_req(2'd1, 27'h2A5A4C3, 0);        // R5 program, bit8 clear
    do_req(2'd1, 27'h1F0F1FF, 1);        // R5 + R10 stray start while busy
    do_req(2'd2, 27'h7FFFFFF, 0);        // R6 erase
    do_req(2'd2, 27'h4C3B2A1, 0);        // R6 erase pattern
    // R10 reserved op while idle
    @(negedge clk);
    start = 1'b1; op = 2'd3; addr = 27'h7FFFFFF;
    @(negedge clk);
    start = 1'b0; op = 2'd0;
    repeat (20) @(negedge clk);
    check(ce_n && we_n && io_oe == 0, "R10", "reserved op left bus idle",
          {ce_n, we_n, io_oe}, {2'b11, 8'h00});
    check(dones == 7, "R10", "done count", dones, 7);
    check(!wp_n, "R8", "wp_n idle", wp_n, 0);
    finish_run();
  end
endmodule